// File: doc/BRIEF.md
# Oversampling Read-Line Deserializer

This block watches one asynchronous read-signal line and takes a sample of it on every clock of a fast sampling clock (16 MHz in the intended system). Samples pass through a short synchronizer and then shift into a register. After a fixed number of samples, the newest group is copied into a holding word. One clock later a single flag bit inverts. A slow host polls the word. It knows a fresh word has arrived when the flag differs from the value it saw on its previous poll. No request or acknowledge exchange is needed.

There are three word formats, selected by a two-bit input. The narrow format gives 8 samples. The two wide formats fill a 16-bit word: either 15 samples, or 14 samples plus the level of an index-hole sensor. In both wide formats the flag occupies the top bit, so one host read returns the data and the readiness indication together. A host read strobe is optional. Using it clears a pending indication, and a sticky overrun bit records any word that replaced one the host never read. The format input is assumed to change only while reset is held.

Top module: `rdsig_deser`

## Requirements
- R1: `rd_in` and `idx_in` each pass through SYNC_STAGES (default 2) flip-flops before use. A word latched at clock edge e holds the `rd_in` levels sampled at edges e-S-N+1 through e-S, where S is SYNC_STAGES and N is the sample count of the format.
- R2: The number of samples per word N is set by `fmt_sel`: 0 gives 8, 1 gives 15, 2 gives 14. The first latch happens on the Nth rising edge after reset is released, and a new latch follows every N edges after that. The holding word changes only at a latch.
- R3: `flag_out` inverts on the edge that follows each latch. The data bits of `word_out` never change on the same edge as the flag.
- R4: With `fmt_sel` = 0, `word_out[7:0]` carries the samples with the oldest in bit 7, and `word_out[15:8]` reads zero.
- R5: With `fmt_sel` = 1, `word_out[14:0]` carries the samples with the oldest in bit 14, and `word_out[15]` equals `flag_out`.
- R6: With `fmt_sel` = 2, `word_out[13:0]` carries the samples with the oldest in bit 13. `word_out[14]` is the synchronized `idx_in` level at the latch edge, which is `idx_in` as sampled S edges earlier. `word_out[15]` equals `flag_out`.
- R7: `pend_out` rises on the edge where the flag inverts. A `host_rd` high at a rising edge clears it on that edge, unless the flag inverts on that same edge.
- R8: `ovr_out` sets when the flag inverts while `pend_out` is high and `host_rd` is low. Once set, it stays set until reset.
- R9: A synchronous active-low reset sets `word_out`, `flag_out`, `pend_out` and `ovr_out` to zero and restarts the sample count.
- R10: `fmt_sel` = 3 behaves exactly like `fmt_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_in | input | 1 | Asynchronous read-signal line |
| idx_in | input | 1 | Asynchronous index-hole sensor level |
| fmt_sel | input | 2 | Word format: 0 narrow, 1 wide 15 samples, 2 wide 14 samples plus index, 3 as 0 |
| host_rd | input | 1 | Optional one-clock host read strobe |
| word_out | output | 16 | Holding word (samples, index bit and flag bit depending on format) |
| flag_out | output | 1 | Toggle flag, inverts once per latched word |
| pend_out | output | 1 | A word is waiting for a host read |
| ovr_out | output | 1 | Sticky: a word was replaced before it was read |

## Verification
The bench builds the block with its default parameters: WORD_W = 16, NARROW_N = 8 and SYNC_STAGES = 2. These defaults make all three word lengths (8, 15 and 14) reachable, so the counter wraps at three different limits and the index bit lands at a bit position that the 15-sample format uses for data. Each format runs with alternating, random and long-run sample patterns, and the spare format code is exercised as well. A run with no host reads drives the overrun bit, and a reset taken in mid-stream shows that every output clears.

// File: rtl/rdsig_pkg.sv
// Shared definitions for the read-line deserializer.
// Assumes: the word width is at least NARROW_N + 1 and at least 4.
package rdsig_pkg;

    // Word format selected at the block's format input.
    typedef enum logic [1:0] {
        FMT_NARROW    = 2'd0,
        FMT_WIDE_FULL = 2'd1,
        FMT_WIDE_IDX  = 2'd2,
        FMT_SPARE     = 2'd3
    } fmt_e;

    // Number of read-line samples that make up one word in a given format.
    function automatic int unsigned word_samples(fmt_e f, int unsigned narrow_n,
                                                 int unsigned word_w);
        case (f)
            FMT_WIDE_FULL: return word_w - 1;
            FMT_WIDE_IDX:  return word_w - 2;
            default:       return narrow_n;
        endcase
    endfunction

    // True for the formats that place the toggle flag in the top word bit.
    function automatic logic flag_in_word(fmt_e f);
        return (f == FMT_WIDE_FULL) || (f == FMT_WIDE_IDX);
    endfunction

endpackage

// File: rtl/rdsig_sync.sv
// Multi-flop synchronizer for a small bundle of asynchronous levels.
// Assumes: STAGES >= 2; every bit is an independent slow level, so no
// bundle coherency is required.
module rdsig_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Move each input level one stage down the chain per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rdsig_capture.sv
// Sample shifter, word counter and holding register.
// Shifts one synchronized sample per clock. When the count reaches the
// format's sample total, it copies the newest samples (plus the index level
// in the index format) into the holding register and pulses latch_o for the
// following cycle.
// Assumes: fmt_i is stable outside reset.
module rdsig_capture
    import rdsig_pkg::*;
#(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned NARROW_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic              idx_i,
    input  fmt_e              fmt_i,
    output logic [WORD_W-2:0] hold_o,
    output logic              latch_o
);

    localparam int unsigned SR_W  = WORD_W - 1;
    localparam int unsigned CNT_W = $clog2(WORD_W);

    logic [SR_W-2:0]  sr_q;
    logic [SR_W-1:0]  sr_next;
    logic [SR_W-1:0]  field;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             at_last;

    // Newest sample enters at bit 0, so older samples sit in higher bits.
    always_comb begin
        sr_next = {sr_q, smp_i};
    end

    // Index of the final sample of a word in the selected format.
    always_comb begin
        last_cnt = CNT_W'(word_samples(fmt_i, NARROW_N, WORD_W) - 1);
        at_last  = (cnt_q >= last_cnt);
    end

    // Arrange the newest samples into the word layout of the format.
    always_comb begin
        field = '0;
        case (fmt_i)
            FMT_WIDE_FULL: field = sr_next;
            FMT_WIDE_IDX: begin
                field           = sr_next;
                field[SR_W-1]   = idx_i;
            end
            default: field[NARROW_N-1:0] = sr_next[NARROW_N-1:0];
        endcase
    end

    // Shift samples, count them, and latch the word on the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            hold_o  <= '0;
            latch_o <= 1'b0;
        end else begin
            sr_q    <= sr_next[SR_W-2:0];
            latch_o <= at_last;
            if (at_last) begin
                cnt_q  <= '0;
                hold_o <= field;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a latch always restarts the sample count.
    p_count_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> (cnt_q == '0));

    // R2: two latches are never adjacent, since every word spans several samples.
    p_latch_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |=> !latch_o);

    // R2: the holding word changes only on the edge that raised latch_o.
    p_hold_only_on_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o != $past(hold_o)) |-> latch_o);

endmodule

// File: rtl/rdsig_handshake.sv
// Toggle flag, pending indication and sticky overrun.
// The flag inverts on the clock after each latch, so the holding word is
// already stable when the host sees the flag move.
// Assumes: latch_i is a single-cycle pulse.
module rdsig_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_i,
    input  logic host_rd_i,
    output logic flag_o,
    output logic pend_o,
    output logic ovr_o
);

    // Invert the flag per word, track unread words and record overruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            pend_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (latch_i) begin
            flag_o <= ~flag_o;
            pend_o <= 1'b1;
            if (pend_o && !host_rd_i) begin
                ovr_o <= 1'b1;
            end
        end else if (host_rd_i) begin
            pend_o <= 1'b0;
        end
    end

    // R3: each latch pulse inverts the flag on the following edge.
    p_flag_follows_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> (flag_o != $past(flag_o)));

    // R7: a new word always leaves the pending indication set.
    p_pend_on_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> pend_o);

    // R7: a host read with no new word clears pending.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !latch_i) |=> !pend_o);

    // R8: overrun is sticky.
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |=> ovr_o);

    // R8: overrun only rises on a word that replaced an unread word.
    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(latch_i && pend_o && !host_rd_i));

endmodule

// File: rtl/rdsig_deser.sv
// Top of the oversampling read-line deserializer.
// Synchronizes the read line and index sensor, builds words of samples, and
// presents them with a toggle flag that a polling host compares against its
// last observed value.
// Assumes: fmt_sel changes only while rst_n is low.
module rdsig_deser
    import rdsig_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned NARROW_N    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_in,
    input  logic              idx_in,
    input  logic [1:0]        fmt_sel,
    input  logic              host_rd,
    output logic [WORD_W-1:0] word_out,
    output logic              flag_out,
    output logic              pend_out,
    output logic              ovr_out
);

    fmt_e              fmt;
    logic [1:0]        sync_q;
    logic [WORD_W-2:0] hold;
    logic              latch;
    logic              flag_bit;

    assign fmt = fmt_e'(fmt_sel);

    rdsig_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({idx_in, rd_in}),
        .q_o   (sync_q)
    );

    rdsig_capture #(
        .WORD_W   (WORD_W),
        .NARROW_N (NARROW_N)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_i   (sync_q[0]),
        .idx_i   (sync_q[1]),
        .fmt_i   (fmt),
        .hold_o  (hold),
        .latch_o (latch)
    );

    rdsig_handshake u_handshake (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_i   (latch),
        .host_rd_i (host_rd),
        .flag_o    (flag_bit),
        .pend_o    (pend_out),
        .ovr_o     (ovr_out)
    );

    // Place the flag in the top bit for the wide formats only.
    always_comb begin
        word_out = {flag_in_word(fmt) ? flag_bit : 1'b0, hold};
        flag_out = flag_bit;
    end

    // R3: the data bits are steady on every edge where the flag moves.
    p_data_before_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_out != $past(flag_out)) |->
            (word_out[WORD_W-2:0] == $past(word_out[WORD_W-2:0])));

    // R4: the narrow formats keep the bits above the samples at zero.
    p_narrow_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_in_word(fmt) |-> (word_out[WORD_W-1:NARROW_N] == '0));

    // R5: the wide formats mirror the flag in the top word bit.
    p_wide_flag_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_in_word(fmt) |-> (word_out[WORD_W-1] == flag_out));

endmodule

// File: tb/test_rdsig_deser.sv
// Scoreboard bench: a posedge model pushes expected words, and a negedge
// monitor pops and compares them when the flag moves.
module test_rdsig_deser;

    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_in = 1'b0;
    logic        idx_in = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        host_rd = 1'b0;
    logic [15:0] word_out;
    logic        flag_out;
    logic        pend_out;
    logic        ovr_out;

    int checks = 0;
    int errors = 0;
    int cur_n = 8;
    int cur_fmt = 0;
    bit auto_rd = 1'b1;
    int toggles = 0;
    int ncount = 0;

    logic [63:0] hv = '0;
    logic [63:0] ih = '0;
    int          mcnt = 0;
    logic [15:0] exp_q[$];

    logic        last_flag = 1'b0;
    logic [14:0] last_data = '0;
    bit          flag_due = 1'b0;
    bit          rd_check_due = 1'b0;

    always #10 clk = ~clk;

    rdsig_deser i_rdsig_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_in    (rd_in),
        .idx_in   (idx_in),
        .fmt_sel  (fmt_sel),
        .host_rd  (host_rd),
        .word_out (word_out),
        .flag_out (flag_out),
        .pend_out (pend_out),
        .ovr_out  (ovr_out)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Model: record samples and push the word expected at each latch edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            hv = '0;
            ih = '0;
            mcnt = 0;
        end else begin
            hv = {hv[62:0], rd_in};
            ih = {ih[62:0], idx_in};
            mcnt++;
            if (mcnt == cur_n) begin
                mcnt = 0;
                case (cur_fmt)
                    1:       exp_q.push_back({1'b0, hv[S+14 -: 15]});
                    2:       exp_q.push_back({1'b0, ih[S], hv[S+13 -: 14]});
                    default: exp_q.push_back({8'b0, hv[S+7 -: 8]});
                endcase
            end
        end
    end

    // Monitor: compare words when the flag moves, and drive host reads.
    always @(negedge clk) begin
        logic [15:0] e;
        if (!rst_n) begin
            last_flag    = 1'b0;
            last_data    = '0;
            flag_due     = 1'b0;
            rd_check_due = 1'b0;
            host_rd      = 1'b0;
            toggles      = 0;
            ncount       = 0;
        end else begin
            ncount++;
            host_rd = 1'b0;
            if (rd_check_due) begin
                chk(pend_out == 1'b0, "R7 read clears pending", {15'b0, pend_out}, 16'h0);
                rd_check_due = 1'b0;
            end
            if (flag_due) begin
                chk(flag_out != last_flag, "R3 flag one clock after data",
                    {15'b0, flag_out}, {15'b0, ~last_flag});
                flag_due = 1'b0;
            end
            if (flag_out != last_flag) begin
                chk(ncount == (toggles + 1) * cur_n + 2, "R2 word period",
                    16'(ncount), 16'((toggles + 1) * cur_n + 2));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", word_out, 16'h0);
                end else begin
                    e = exp_q.pop_front();
                    if (cur_fmt == 1 || cur_fmt == 2) begin
                        chk(word_out[14:0] == e[14:0], "R1 R5 R6 wide word data",
                            {1'b0, word_out[14:0]}, e);
                        chk(word_out[15] == flag_out, "R5 R6 flag in top bit",
                            {15'b0, word_out[15]}, {15'b0, flag_out});
                    end else begin
                        chk(word_out == e, "R1 R4 R10 narrow word", word_out, e);
                    end
                end
                chk(pend_out == 1'b1, "R7 pending on new word", {15'b0, pend_out}, 16'h1);
                if (auto_rd) begin
                    host_rd = 1'b1;
                    rd_check_due = 1'b1;
                end else begin
                    chk(ovr_out == (toggles >= 1), "R8 overrun on unread word",
                        {15'b0, ovr_out}, {15'b0, toggles >= 1});
                end
                toggles++;
                last_flag = flag_out;
            end else if (word_out[14:0] != last_data) begin
                flag_due = 1'b1;
            end
            last_data = word_out[14:0];
        end
    end

    // Hold reset, select a format, check cleared outputs, then release.
    task automatic do_reset(input int fmt, input bit rd_mode);
        @(posedge clk); #5;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        fmt_sel = 2'(fmt);
        cur_fmt = fmt;
        cur_n   = (fmt == 1) ? 15 : (fmt == 2) ? 14 : 8;
        auto_rd = rd_mode;
        rd_in   = 1'b0;
        idx_in  = 1'b0;
        @(posedge clk); #5;
        exp_q.delete();
        #5;
        chk(word_out == 16'h0, "R9 reset word", word_out, 16'h0);
        chk({flag_out, pend_out, ovr_out} == 3'b0, "R9 reset flags",
            {13'b0, flag_out, pend_out, ovr_out}, 16'h0);
        @(posedge clk); #5;
        rst_n = 1'b1;
    endtask

    // Drive the read line: 0 alternating, 1 random, 2 runs of 13 clocks.
    task automatic drive(input int kind, input int cycles, input bit idx_moves);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #5;
            case (kind)
                0:       rd_in = rd_in ^ 1'b1;
                1:       rd_in = 1'($urandom_range(0, 1));
                default: if (i % 13 == 0) rd_in = ~rd_in;
            endcase
            if (idx_moves && (i % 20 == 0)) idx_in = ~idx_in;
        end
    endtask

    initial begin
        // R4: narrow format, host reads each word.
        do_reset(0, 1'b1);
        drive(0, 8 * 6, 1'b0);
        drive(1, 8 * 10, 1'b0);
        drive(2, 8 * 8 + 4, 1'b0);
        #5;
        chk(ovr_out == 1'b0, "R8 no overrun when read", {15'b0, ovr_out}, 16'h0);

        // R5: wide format with 15 samples.
        do_reset(1, 1'b1);
        drive(2, 15 * 6, 1'b0);
        drive(1, 15 * 8, 1'b0);
        drive(0, 15 * 3 + 4, 1'b0);
        #5;
        chk(ovr_out == 1'b0, "R8 no overrun wide", {15'b0, ovr_out}, 16'h0);

        // R6: wide format with index level.
        do_reset(2, 1'b1);
        drive(1, 14 * 12, 1'b1);
        drive(2, 14 * 6 + 4, 1'b1);

        // R10: spare code acts as narrow.
        do_reset(3, 1'b1);
        drive(0, 8 * 4, 1'b0);
        drive(1, 8 * 4 + 4, 1'b0);

        // R8: no host reads, overrun must set and stay.
        do_reset(0, 1'b0);
        drive(1, 8 * 5 + 4, 1'b0);
        #5;
        chk(ovr_out == 1'b1, "R8 overrun sticky", {15'b0, ovr_out}, 16'h1);
        chk(toggles == 5, "R2 word count", 16'(toggles), 16'd5);

        // R9: reset in mid-stream clears all outputs.
        do_reset(0, 1'b1);
        drive(1, 20, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule